// File: doc/BRIEF.md
# Pipelined NCO Phase Accumulator Core

This block is the phase and amplitude engine of a numerically controlled oscillator. A 32-bit tuning word comes from a serial shift register outside the block. A delayed transfer strobe copies that word into an increment register. While accumulation is enabled, a 32-bit phase accumulator adds the increment on every clock. A clear input zeroes the accumulator's feedback path, so the next sum restarts from the increment alone.

A two-bit quadrant code rotates the phase by whole quarter turns before the amplitude lookup. The twelve most significant bits of the rotated phase index a sine table. The table stores one quarter of a wave, fills itself at elaboration, and has mirror and sign folding applied around it. The output is 12-bit unsigned offset binary, with mid-scale representing zero. Each control has its own fixed pipeline latency, so a controller can line up strobes with phase changes that it has already scheduled.

Top module: `nco_core`

## Requirements
- R1: A synchronous reset clears the increment, the accumulator and every pipeline stage. In the first sample after reset `amp` reads 2048, and it stays there until a control acts.
- R2: If `xfer_n` is low at clock edge n, the increment register takes the `freq_word` value sampled at that same edge n. It does so at edge n+4.
- R3: If `acc_en_n` is low at edge n, the accumulator adds the increment at edge n+4, modulo 2^32. If `acc_en_n` is high at edge n, the accumulator keeps its value at edge n+4.
- R4: If `load_n` is low at edge n and accumulation is enabled for edge n+5, the accumulator takes exactly the increment value at edge n+5.
- R5: A `phase_sel` value sampled at edge n is added to the top two accumulator bits in the phase formed at edge n+4. The codes 0, 1, 2 and 3 add 0, 90, 180 and 270 degrees.
- R6: `amp` (bit 0 is the LSB) equals 2048 + 2047·sin(2π·P/4096) within ±2 LSB. P is the top 12 bits of the rotated phase. With a zero accumulator, the codes 1, 2 and 3 give exactly 4095, 2048 and 1.
- R7: `amp` after edge n reflects the accumulator value after edge n-3 and the `phase_sel` value sampled at edge n-6.
- R8: The accumulator wraps modulo 2^32. Near-full-scale increments therefore step the phase backwards without disturbing the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_word | input | 32 | Tuning word from the external serial register |
| xfer_n | input | 1 | Active-low transfer of `freq_word` into the increment register |
| acc_en_n | input | 1 | Active-low accumulate enable |
| load_n | input | 1 | Active-low feedback clear for the accumulator |
| phase_sel | input | 2 | Quadrant phase offset code |
| amp | output | 12 | Unsigned offset-binary sine amplitude |

## Verification
A wrong increment or accumulator value shows up at `amp` three clocks after the bad update. It persists as a frequency or phase error that grows with every following step. A stage too many or too few in any control delay line moves the first amplitude change by one cycle, and the bench catches this against a cycle-exact model. A fault in the table folding shows up as a wrong sign or a wrong mirror in one quadrant. The exact quadrant-point outputs expose it at once.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int ACC_W  = 32;
  localparam int PH_W   = 12;
  localparam int AMP_W  = 12;
  localparam int QSEL_W = 2;

  typedef struct packed {
    logic              xfer_n;
    logic              en_n;
    logic [QSEL_W-1:0] qsel;
    logic [ACC_W-1:0]  word;
  } ctl_t;
endpackage

// File: rtl/nco_dly.sv
module nco_dly #(
  parameter int           W       = 1,
  parameter int           D       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [D];

  for (genvar i = 0; i < D; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[D-1];
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer,
  input  logic             step,
  input  logic             zero_fb,
  input  logic [ACC_W-1:0] word,
  output logic [ACC_W-1:0] inc_q,
  output logic [ACC_W-1:0] acc_q
);
  logic [ACC_W-1:0] fb;

  assign fb = zero_fb ? '0 : acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q <= '0;
      acc_q <= '0;
    end else begin
      if (xfer) inc_q <= word;
      if (step) acc_q <= fb + inc_q;
    end
  end
endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut #(
  parameter int PH_W  = 12,
  parameter int AMP_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  ph,
  output logic [AMP_W-1:0] amp
);
  localparam int IDX_W = PH_W - 2;
  localparam int QW    = 2 ** IDX_W;
  localparam int MAG_W = AMP_W - 1;
  localparam int FULL  = 2 ** MAG_W - 1;
  localparam int MID   = 2 ** MAG_W;
  localparam real PI   = 3.14159265358979323846;

  function automatic logic [MAG_W-1:0] qsin(input int i);
    real r;
    r = $sin(2.0 * PI * i / (4.0 * QW)) * FULL;
    return MAG_W'($rtoi(r + 0.5));
  endfunction

  logic [MAG_W-1:0] rom [QW];

  initial begin
    for (int i = 0; i < QW; i++) rom[i] = qsin(i);
  end

  logic [IDX_W-1:0] idx;
  logic [IDX_W:0]   addr_full;
  logic             mirror;

  assign mirror    = ph[PH_W-2];
  assign idx       = ph[IDX_W-1:0];
  assign addr_full = mirror ? ((IDX_W+1)'(QW) - {1'b0, idx}) : {1'b0, idx};

  logic [MAG_W-1:0] mag_q;
  logic             full_q;
  logic             neg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q  <= '0;
      full_q <= 1'b0;
      neg_q  <= 1'b0;
    end else begin
      mag_q  <= rom[addr_full[IDX_W-1:0]];
      full_q <= addr_full[IDX_W];
      neg_q  <= ph[PH_W-1];
    end
  end

  logic [AMP_W-1:0] m_ext;
  logic [AMP_W-1:0] mid_v;

  assign m_ext = full_q ? AMP_W'(FULL) : {1'b0, mag_q};
  assign mid_v = AMP_W'(MID);

  always_ff @(posedge clk) begin
    if (rst) amp <= mid_v;
    else     amp <= neg_q ? (mid_v - m_ext) : (mid_v + m_ext);
  end
endmodule

// File: rtl/nco_core.sv
module nco_core
  import nco_pkg::*;
#(
  parameter int XFER_DLY = 4,
  parameter int LOAD_DLY = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  freq_word,
  input  logic              xfer_n,
  input  logic              acc_en_n,
  input  logic              load_n,
  input  logic [QSEL_W-1:0] phase_sel,
  output logic [AMP_W-1:0]  amp
);
  localparam int   CTL_W   = $bits(ctl_t);
  localparam ctl_t CTL_RST = '{xfer_n: 1'b1, en_n: 1'b1, qsel: '0, word: '0};

  ctl_t ctl_in, ctl_d;
  logic load_d;

  assign ctl_in = '{xfer_n: xfer_n, en_n: acc_en_n, qsel: phase_sel, word: freq_word};

  nco_dly #(.W(CTL_W), .D(XFER_DLY), .RST_VAL(CTL_RST)) u_ctl_dly (
    .clk(clk), .rst(rst), .din(ctl_in), .dout(ctl_d)
  );

  nco_dly #(.W(1), .D(LOAD_DLY), .RST_VAL(1'b1)) u_load_dly (
    .clk(clk), .rst(rst), .din(load_n), .dout(load_d)
  );

  logic [ACC_W-1:0] inc_q;
  logic [ACC_W-1:0] acc_q;

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst),
    .xfer(~ctl_d.xfer_n), .step(~ctl_d.en_n), .zero_fb(~load_d),
    .word(ctl_d.word), .inc_q(inc_q), .acc_q(acc_q)
  );

  logic [ACC_W-1:0] rot;
  logic [PH_W-1:0]  ph_q;

  assign rot = acc_q + {ctl_d.qsel, {(ACC_W-QSEL_W){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= rot[ACC_W-1 -: PH_W];
  end

  nco_sine_lut #(.PH_W(PH_W), .AMP_W(AMP_W)) u_lut (
    .clk(clk), .rst(rst), .ph(ph_q), .amp(amp)
  );
endmodule

// File: rtl/nco_core_chk.sv
module nco_core_chk #(
  parameter int ACC_W    = 32,
  parameter int AMP_W    = 12,
  parameter int XFER_DLY = 4,
  parameter int LOAD_DLY = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [ACC_W-1:0] freq_word,
  input logic             xfer_n,
  input logic             acc_en_n,
  input logic             load_n,
  input logic [ACC_W-1:0] inc,
  input logic [ACC_W-1:0] acc,
  input logic [AMP_W-1:0] amp
);
  logic [3:0] since;

  always_ff @(posedge clk) begin
    if (rst)             since <= '0;
    else if (since != 4'hF) since <= since + 4'd1;
  end

  logic ok;
  assign ok = (since > 4'(LOAD_DLY + 2));

  a_r1_reset_mid: assert property (@(posedge clk) rst |=> amp == AMP_W'(2 ** (AMP_W-1)));

  a_r2_xfer: assert property (@(posedge clk) disable iff (rst)
    (ok && !$past(xfer_n, XFER_DLY+1)) |-> inc == $past(freq_word, XFER_DLY+1));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (ok && $past(acc_en_n, XFER_DLY+1)) |-> acc == $past(acc));

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (ok && !$past(acc_en_n, XFER_DLY+1) && $past(load_n, LOAD_DLY+1))
      |-> acc == $past(acc) + $past(inc));

  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    (ok && !$past(acc_en_n, XFER_DLY+1) && !$past(load_n, LOAD_DLY+1))
      |-> acc == $past(inc));

  a_r6_nonzero: assert property (@(posedge clk) disable iff (rst)
    ok |-> amp != '0);
endmodule

bind nco_core nco_core_chk #(
  .ACC_W(nco_pkg::ACC_W), .AMP_W(nco_pkg::AMP_W),
  .XFER_DLY(XFER_DLY), .LOAD_DLY(LOAD_DLY)
) u_chk (
  .clk(clk), .rst(rst), .freq_word(freq_word), .xfer_n(xfer_n),
  .acc_en_n(acc_en_n), .load_n(load_n), .inc(inc_q), .acc(acc_q), .amp(amp)
);

// File: tb/nco_core_tb.sv
module nco_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] freq_word = '0;
  logic        xfer_n = 1'b1;
  logic        acc_en_n = 1'b1;
  logic        load_n = 1'b1;
  logic [1:0]  phase_sel = '0;
  logic [11:0] amp;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nco_core u_dut (
    .clk(clk), .rst(rst), .freq_word(freq_word), .xfer_n(xfer_n),
    .acc_en_n(acc_en_n), .load_n(load_n), .phase_sel(phase_sel), .amp(amp)
  );

  // Cycle model written from the requirements (index = edges ago).
  logic [31:0] h_word [6];
  logic        h_xf [6];
  logic        h_en [6];
  logic        h_ld [6];
  logic [1:0]  h_ps [6];
  logic [31:0] m_acc, m_inc;
  logic [11:0] m_ph [3];

  always @(posedge clk) begin
    logic [31:0] rot;
    if (rst) begin
      for (int k = 0; k < 6; k++) begin
        h_word[k] = '0; h_xf[k] = 1'b1; h_en[k] = 1'b1; h_ld[k] = 1'b1; h_ps[k] = '0;
      end
      m_acc = '0; m_inc = '0;
      for (int k = 0; k < 3; k++) m_ph[k] = '0;
    end else begin
      for (int k = 5; k > 0; k--) begin
        h_word[k] = h_word[k-1]; h_xf[k] = h_xf[k-1]; h_en[k] = h_en[k-1];
        h_ld[k] = h_ld[k-1]; h_ps[k] = h_ps[k-1];
      end
      h_word[0] = freq_word; h_xf[0] = xfer_n; h_en[0] = acc_en_n;
      h_ld[0] = load_n; h_ps[0] = phase_sel;
      m_ph[2] = m_ph[1];
      m_ph[1] = m_ph[0];
      rot = m_acc + {h_ps[4], 30'b0};      // R5
      m_ph[0] = rot[31:20];
      if (!h_en[4]) m_acc = (h_ld[5] ? m_acc : 32'd0) + m_inc;  // R3 R4 R8
      if (!h_xf[4]) m_inc = h_word[4];     // R2
    end
  end

  task automatic check_model(input string req);
    real e, d;
    e = 2048.0 + 2047.0 * $sin(2.0 * 3.14159265358979 * m_ph[2] / 4096.0);
    d = real'(amp) - e;
    checks++;
    if (d > 2.0 || d < -2.0) begin
      errors++;
      $display("FAIL %s: amp=%0d expected=%0.2f (phase %0d)", req, amp, e, m_ph[2]);
    end
  endtask

  task automatic check_exact(input string req, input logic [11:0] exp);
    checks++;
    if (amp !== exp) begin
      errors++;
      $display("FAIL %s: amp=%0d expected=%0d", req, amp, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; xfer_n = 1'b1; acc_en_n = 1'b1; load_n = 1'b1; phase_sel = '0; freq_word = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] word;
    logic        xf;
    logic        en;
    logic        ld;
    logic [1:0]  ps;
    logic [7:0]  cyc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0100_0000, 1'b0, 1'b1, 1'b1, 2'd0, 8'd6,  4'd2},  // R2 transfer, no stepping
    '{32'h0100_0000, 1'b1, 1'b0, 1'b1, 2'd0, 8'd40, 4'd3},  // R3 stepping
    '{32'h0100_0000, 1'b1, 1'b1, 1'b1, 2'd0, 8'd10, 4'd3},  // R3 hold
    '{32'h0100_0000, 1'b1, 1'b0, 1'b0, 2'd0, 8'd3,  4'd4},  // R4 clear feedback
    '{32'h0100_0000, 1'b1, 1'b0, 1'b1, 2'd1, 8'd12, 4'd5},  // R5 90 deg
    '{32'h0100_0000, 1'b1, 1'b0, 1'b1, 2'd2, 8'd8,  4'd5},  // R5 180 deg
    '{32'h0100_0000, 1'b1, 1'b0, 1'b1, 2'd3, 8'd8,  4'd5},  // R5 270 deg
    '{32'h3456_7891, 1'b0, 1'b0, 1'b1, 2'd0, 8'd2,  4'd2},  // R2 new word
    '{32'h3456_7891, 1'b1, 1'b0, 1'b1, 2'd0, 8'd60, 4'd8},  // R8 forward wrap
    '{32'hFF00_0000, 1'b0, 1'b0, 1'b1, 2'd1, 8'd2,  4'd2},  // R2 large word
    '{32'hFF00_0000, 1'b1, 1'b0, 1'b1, 2'd1, 8'd30, 4'd8},  // R8 backward steps
    '{32'h0000_0000, 1'b1, 1'b0, 1'b0, 2'd0, 8'd12, 4'd6}   // R6 clear with zero increment
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: all requirements, actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_exact("R1", 12'd2048);
    end

    // Table walk with per-cycle model comparison (R6 amplitude, R7 alignment)
    for (int v = 0; v < NV; v++) begin
      freq_word = VECS[v].word; xfer_n = VECS[v].xf; acc_en_n = VECS[v].en;
      load_n = VECS[v].ld; phase_sel = VECS[v].ps;
      for (int c = 0; c < int'(VECS[v].cyc); c++) begin
        @(negedge clk);
        check_model($sformatf("R%0d", VECS[v].req));
      end
    end
    xfer_n = 1'b1; acc_en_n = 1'b1; load_n = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      check_model("R3");
    end

    // R1: reset in mid-run returns to mid-scale
    do_reset();
    @(negedge clk);
    check_exact("R1", 12'd2048);

    // R7: quadrant code latency, R6 exact quadrant points
    phase_sel = 2'd1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      check_exact("R7", 12'd2048);
    end
    @(negedge clk);
    check_exact("R7", 12'd4095);
    phase_sel = 2'd2;
    repeat (7) @(negedge clk);
    check_exact("R6", 12'd2048);
    phase_sel = 2'd3;
    repeat (7) @(negedge clk);
    check_exact("R6", 12'd1);
    phase_sel = 2'd0;
    repeat (7) @(negedge clk);
    check_exact("R6", 12'd2048);

    // R2/R3 latency: a quarter-turn increment, one enabled step
    freq_word = 32'h4000_0000; xfer_n = 1'b0;
    @(negedge clk);
    xfer_n = 1'b1;
    repeat (4) @(negedge clk);
    acc_en_n = 1'b0;
    @(negedge clk);
    acc_en_n = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      check_exact("R3", 12'd2048);
    end
    @(negedge clk);
    check_exact("R3", 12'd4095);
    repeat (5) @(negedge clk);
    check_exact("R3", 12'd4095);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule